// File: doc/BRIEF.md
# Don't-Care Bit Fill Engine

This block turns a partly specified test pattern into a fully specified one. Each request carries a value vector, a care mask and a fill policy. Positions whose mask bit is 1 are care bits and are passed through unchanged. Positions whose mask bit is 0 are don't-care bits, and the engine gives them a value according to the chosen policy. The policies are constant 0, constant 1, a value copied from the neighbouring care bit, and a pseudorandom value. The filled vector is ready to be shifted into a scan chain. The engine also reports how many adjacent bit pairs of the result differ, which gives a measure of shift activity.

Requests enter through a valid/ready handshake and results leave through a second one. The output stage holds one result. The whole pattern is filled in the cycle it is accepted, so the engine can take one pattern per clock when the consumer does not stall. A 16-bit pseudorandom generator supplies the random fill. A non-zero seed can be loaded into it at any time.

Top module: `xfill_engine`

## Requirements
- R1: `in_ready` is high exactly when the output stage is empty or `out_ready` is high. A pattern accepted on a clock edge (`in_valid` and `in_ready` both high) is shown on `out_pattern` and `out_toggles` with `out_valid` high right after that edge. `out_valid` falls after an edge with `out_ready` high and no new pattern accepted.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pattern` and `out_toggles` stay unchanged.
- R3: In every mode, each position whose `in_care` bit is 1 carries the matching `in_value` bit on `out_pattern`.
- R4: Mode code 0 puts 0 in every don't-care position.
- R5: Mode code 1 puts 1 in every don't-care position.
- R6: Mode code 2 fills by adjacency. Bit 0 is shifted first. Each don't-care position takes the value of the nearest care bit at a lower index. Don't-care positions below the first care bit take that first care bit's value. For example, care only at bit 0 (value 0) and bit 4 (value 1) gives 0 in bits 0 to 3 and 1 in bits 4 to 15.
- R7: In mode code 2, a pattern with no care bits becomes all zeros.
- R8: Mode code 3 uses a 16-bit register S. Don't-care positions are visited in ascending index order. For each one, the position takes S[15] and S then becomes {S[14:0], S[15]^S[13]^S[12]^S[10]}. Care bits do not advance S. S changes only on accepted mode-3 patterns and on seed loads.
- R9: S resets to 16'hACE1. When `seed_load` is high at an edge and `seed_value` is non-zero, S takes `seed_value`. A zero seed is ignored. A mode-3 pattern accepted at the same edge is filled from the old S, and the seed wins the update.
- R10: `out_toggles` equals the number of indices i from 1 to width-1 at which bit i of `out_pattern` differs from bit i-1.
- R11: After reset, `out_valid`, `out_pattern` and `out_toggles` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load `seed_value` into the random generator |
| seed_value | input | 16 | New generator state (ignored when zero) |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Engine can accept a request |
| in_mode | input | 2 | Fill policy: 0 zeros, 1 ones, 2 adjacent, 3 random |
| in_value | input | PAT_W | Pattern values |
| in_care | input | PAT_W | 1 marks a care bit |
| out_valid | output | 1 | Filled pattern available |
| out_ready | input | 1 | Consumer takes the result |
| out_pattern | output | PAT_W | Fully specified pattern |
| out_toggles | output | $clog2(PAT_W) | Count of differing adjacent bit pairs |

## Verification
The bench targets the adjacency edge cases: the 0XXX1XX-style case, patterns with don't-care bits only ahead of the first care bit, and patterns with no care bits at all. A wrong fill direction would give 1s in the low run, and a missing fallback would leave leading bits at 0 instead of the first care value. In random mode it mixes care and don't-care bits, loads seeds while idle, loads a zero seed and loads a seed in the same cycle as a fill. An engine that advanced the generator on care bits, honoured a zero seed or let the seed feed the fill would drift from the model from then on. It also stalls the consumer for long stretches while a request waits. An engine that dropped or overwrote a result, or let the output move, would show a mismatched or missing pattern. The alternating all-care pattern drives the toggle count to its maximum.

// File: rtl/xfill_pkg.sv
package xfill_pkg;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_ONE  = 2'd1,
    FILL_ADJ  = 2'd2,
    FILL_RAND = 2'd3
  } fill_mode_e;

  localparam int          PRNG_W     = 16;
  localparam logic [15:0] PRNG_RESET = 16'hACE1;

  // One step of the maximal-length generator x^16 + x^14 + x^13 + x^11 + 1.
  function automatic logic [PRNG_W-1:0] prng_step(input logic [PRNG_W-1:0] s);
    return {s[PRNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/xfill_adjacent.sv
module xfill_adjacent #(
  parameter int W = 16
) (
  input  logic [W-1:0] value_i,
  input  logic [W-1:0] care_i,
  output logic [W-1:0] pat_o
);

  logic first_val;
  logic found;
  logic carry;

  // Value of the lowest-index care bit, 0 when no care bit exists.
  always_comb begin
    first_val = 1'b0;
    found     = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (care_i[i] && !found) begin
        first_val = value_i[i];
        found     = 1'b1;
      end
    end
  end

  // Forward pass in shift order: every care bit refreshes the carried value.
  always_comb begin
    carry = first_val;
    for (int i = 0; i < W; i++) begin
      if (care_i[i]) carry = value_i[i];
      pat_o[i] = carry;
    end
  end

endmodule

// File: rtl/xfill_random.sv
module xfill_random #(
  parameter int W = 16
) (
  input  logic [15:0]  state_i,
  input  logic [W-1:0] value_i,
  input  logic [W-1:0] care_i,
  output logic [W-1:0] pat_o,
  output logic [15:0]  state_o
);
  import xfill_pkg::*;

  logic [15:0] s;

  // The generator advances once per don't-care bit, in ascending order.
  always_comb begin
    s = state_i;
    for (int i = 0; i < W; i++) begin
      if (care_i[i]) begin
        pat_o[i] = value_i[i];
      end else begin
        pat_o[i] = s[15];
        s        = prng_step(s);
      end
    end
    state_o = s;
  end

endmodule

// File: rtl/xfill_toggle_count.sv
module xfill_toggle_count #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input  logic [W-1:0]  pat_i,
  output logic [CW-1:0] count_o
);

  always_comb begin
    count_o = '0;
    for (int i = 1; i < W; i++) begin
      count_o = count_o + CW'(pat_i[i] ^ pat_i[i-1]);
    end
  end

endmodule

// File: rtl/xfill_engine.sv
module xfill_engine #(
  parameter int PAT_W = 16,
  localparam int CNT_W = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [15:0]      seed_value,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_mode,
  input  logic [PAT_W-1:0] in_value,
  input  logic [PAT_W-1:0] in_care,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAT_W-1:0] out_pattern,
  output logic [CNT_W-1:0] out_toggles
);
  import xfill_pkg::*;

  logic             valid_q, valid_d;
  logic [PAT_W-1:0] pat_q, pat_d;
  logic [CNT_W-1:0] tgl_q, tgl_d;
  logic [15:0]      prng_q, prng_d;

  logic             accept;
  logic             data_en;
  fill_mode_e       mode;
  logic [PAT_W-1:0] adj_pat;
  logic [PAT_W-1:0] rnd_pat;
  logic [15:0]      rnd_state;
  logic [PAT_W-1:0] fill_pat;
  logic [CNT_W-1:0] fill_tgl;

  assign mode     = fill_mode_e'(in_mode);
  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;
  assign data_en  = accept;

  xfill_adjacent #(.W(PAT_W)) u_adj (
    .value_i (in_value),
    .care_i  (in_care),
    .pat_o   (adj_pat)
  );

  xfill_random #(.W(PAT_W)) u_rnd (
    .state_i (prng_q),
    .value_i (in_value),
    .care_i  (in_care),
    .pat_o   (rnd_pat),
    .state_o (rnd_state)
  );

  always_comb begin
    case (mode)
      FILL_ZERO: fill_pat = in_value & in_care;
      FILL_ONE:  fill_pat = in_value | ~in_care;
      FILL_ADJ:  fill_pat = adj_pat;
      FILL_RAND: fill_pat = rnd_pat;
      default:   fill_pat = in_value & in_care;
    endcase
  end

  xfill_toggle_count #(.W(PAT_W), .CW(CNT_W)) u_tgl (
    .pat_i   (fill_pat),
    .count_o (fill_tgl)
  );

  // Next-state logic
  always_comb begin
    valid_d = valid_q;
    if (accept)         valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    pat_d = fill_pat;
    tgl_d = fill_tgl;
    prng_d = prng_q;
    if (accept && mode == FILL_RAND) prng_d = rnd_state;
    if (seed_load && seed_value != 16'd0) prng_d = seed_value;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pat_q   <= '0;
      tgl_q   <= '0;
      prng_q  <= PRNG_RESET;
    end else begin
      valid_q <= valid_d;
      prng_q  <= prng_d;
      if (data_en) begin
        pat_q <= pat_d;
        tgl_q <= tgl_d;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_pattern = pat_q;
  assign out_toggles = tgl_q;

  AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid) else $error("load lost"); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pattern) && $stable(out_toggles)))
    else $error("stalled output moved"); // R2

  AST_CARE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept) |-> (((out_pattern ^ $past(in_value)) & $past(in_care)) == '0))
    else $error("care bit altered"); // R3

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept && in_mode == 2'd0) |-> ((out_pattern & ~$past(in_care)) == '0))
    else $error("zero fill wrong"); // R4

  AST_ONE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept && in_mode == 2'd1) |-> ((out_pattern | $past(in_care)) == '1))
    else $error("one fill wrong"); // R5

  AST_PRNG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    prng_q != 16'd0) else $error("generator stuck at zero"); // R9

endmodule

// File: tb/xfill_engine_bench.sv
module xfill_engine_bench;
  localparam int PAT_W = 16;
  localparam int CNT_W = $clog2(PAT_W);

  logic             clk;
  logic             rst_n;
  logic             seed_load;
  logic [15:0]      seed_value;
  logic             in_valid;
  logic             in_ready;
  logic [1:0]       in_mode;
  logic [PAT_W-1:0] in_value;
  logic [PAT_W-1:0] in_care;
  logic             out_valid;
  logic             out_ready;
  logic [PAT_W-1:0] out_pattern;
  logic [CNT_W-1:0] out_toggles;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int bp_mode = 0;
  bit done = 0;

  xfill_engine #(.PAT_W(PAT_W)) u_xfill_engine (
    .clk, .rst_n, .seed_load, .seed_value, .in_valid, .in_ready,
    .in_mode, .in_value, .in_care, .out_valid, .out_ready,
    .out_pattern, .out_toggles
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Reference model state
  int model_s = 16'hACE1;
  bit seed_evt = 0;
  logic [PAT_W-1:0] q_pat[$];
  int               q_tgl[$];
  string            q_lbl[$];
  logic [PAT_W-1:0] q_val[$];
  logic [PAT_W-1:0] q_care[$];
  bit               prev_hold = 0;
  logic [PAT_W-1:0] prev_pat;
  logic [CNT_W-1:0] prev_tgl;

  function automatic int nxt(input int s);
    int fb;
    fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
    return ((s << 1) | fb) & 16'hFFFF;
  endfunction

  task automatic model_push(input logic [1:0] m, input logic [PAT_W-1:0] v,
                            input logic [PAT_W-1:0] c);
    logic [PAT_W-1:0] r;
    int t;
    int ncare;
    string lbl;
    ncare = 0;
    for (int i = 0; i < PAT_W; i++) if (c[i]) ncare++;
    for (int i = 0; i < PAT_W; i++) begin
      if (c[i]) r[i] = v[i];
      else begin
        case (m)
          2'd0: r[i] = 1'b0;
          2'd1: r[i] = 1'b1;
          2'd2: begin
            int j;
            r[i] = 1'b0;
            j = i;
            while (j >= 0 && !c[j]) j--;
            if (j >= 0) r[i] = v[j];
            else begin
              j = i + 1;
              while (j < PAT_W && !c[j]) j++;
              if (j < PAT_W) r[i] = v[j];
            end
          end
          default: begin
            r[i] = model_s[15];
            model_s = nxt(model_s);
          end
        endcase
      end
    end
    t = 0;
    for (int i = 1; i < PAT_W; i++) if (r[i] != r[i-1]) t++;
    case (m)
      2'd0: lbl = "R4";
      2'd1: lbl = "R5";
      2'd2: lbl = (ncare == 0) ? "R7" : "R6";
      default: begin
        lbl = seed_evt ? "R9" : "R8";
        seed_evt = 0;
      end
    endcase
    q_pat.push_back(r);
    q_tgl.push_back(t);
    q_lbl.push_back(lbl);
    q_val.push_back(v);
    q_care.push_back(c);
  endtask

  // Monitor: sample away from the active edge, update model for the next edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      if (prev_hold) begin
        check("R2 valid held", out_valid, 1);
        check("R2 pattern held", out_pattern, prev_pat);
        check("R2 toggles held", out_toggles, prev_tgl);
      end
      check("R1 ready", in_ready, (!out_valid || out_ready));
      check("R1 valid", out_valid, (q_pat.size() != 0));
      if (out_valid && q_pat.size() != 0) begin
        check(q_lbl[0], out_pattern, q_pat[0]);
        check("R3 care", (out_pattern ^ q_val[0]) & q_care[0], 0);
        check("R10 toggles", out_toggles, q_tgl[0]);
        if (out_ready) begin
          void'(q_pat.pop_front()); void'(q_tgl.pop_front()); void'(q_lbl.pop_front());
          void'(q_val.pop_front()); void'(q_care.pop_front());
        end
      end
      if (in_valid && in_ready) model_push(in_mode, in_value, in_care);
      if (seed_load) begin
        seed_evt = 1;
        if (seed_value != 16'd0) model_s = seed_value;
      end
      prev_hold = out_valid && !out_ready;
      prev_pat  = out_pattern;
      prev_tgl  = out_toggles;
    end
  end

  // Consumer back-pressure
  always @(posedge clk) begin
    #1;
    case (bp_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3 == 0);
      default: out_ready = 1'b0;
    endcase
  end

  task automatic send(input logic [1:0] m, input logic [PAT_W-1:0] v,
                      input logic [PAT_W-1:0] c, input bit sl, input logic [15:0] sv);
    bit acc;
    @(posedge clk); #1;
    in_valid = 1'b1; in_mode = m; in_value = v; in_care = c;
    seed_load = sl; seed_value = sv;
    do begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk); #1;
      seed_load = 1'b0;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic seed_only(input logic [15:0] sv);
    @(posedge clk); #1;
    seed_load = 1'b1; seed_value = sv;
    @(posedge clk); #1;
    seed_load = 1'b0;
  endtask

  task automatic drain();
    bp_mode = 0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'd0; in_value = '0; in_care = '0;
    seed_load = 1'b0; seed_value = 16'd0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R11 valid", out_valid, 0);
    check("R11 pattern", out_pattern, 0);
    check("R11 toggles", out_toggles, 0);
    check("R1 ready after reset", in_ready, 1);

    // R6: 0XXX1XX style
    send(2'd2, 16'h0010, 16'h0011, 0, 0);
    @(negedge clk);
    check("R6 example", out_pattern, 16'hFFF0);
    send(2'd2, 16'h0000, 16'h0000, 0, 0);       // R7
    send(2'd2, 16'h0200, 16'h0200, 0, 0);       // R6 leading run
    send(2'd2, 16'h5555, 16'hFFFF, 0, 0);       // R10 max toggles
    @(negedge clk);
    check("R10 max", out_toggles, 15);
    send(2'd2, 16'h8421, 16'h8C63, 0, 0);
    send(2'd0, 16'hFFFF, 16'h0F0F, 0, 0);       // R4
    send(2'd1, 16'h0000, 16'hF0F0, 0, 0);       // R5
    send(2'd3, 16'h00FF, 16'h00F0, 0, 0);       // R8
    send(2'd3, 16'h0000, 16'h0000, 0, 0);
    drain();
    seed_only(16'h1234);                        // R9
    send(2'd3, 16'hAAAA, 16'h0C30, 0, 0);
    seed_only(16'h0000);                        // R9 zero ignored
    send(2'd3, 16'h0000, 16'h0000, 0, 0);
    send(2'd3, 16'h1111, 16'h1111, 1, 16'hBEEF); // R9 same-cycle
    send(2'd3, 16'h0000, 16'h8001, 0, 0);
    drain();

    // R2: long stall with a request waiting
    bp_mode = 2;
    send(2'd1, 16'h0001, 16'h0003, 0, 0);
    fork
      send(2'd2, 16'h0100, 16'h0180, 0, 0);
      begin repeat (8) @(posedge clk); bp_mode = 0; end
    join
    drain();

    // Mixed stream under intermittent back-pressure
    bp_mode = 1;
    for (int k = 0; k < 40; k++) begin
      send(2'(k % 4), 16'(k * 40503 + 7), 16'((k * 13849) ^ (k << 5)), (k % 9 == 4),
           16'(k * 291 + 1));
    end
    drain();
    repeat (5) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule